// File: doc/BRIEF.md
# Cascadable Synchronous Binary Counter

This block is a wide synchronous up-counter assembled from identical 4-bit slices. Each slice holds four count bits and raises a carry flag when it sits at its top value while its carry-in enable is high. Each slice passes that flag to the carry-in enable of the slice above it. An upper slice therefore advances on exactly the edge at which every slice below it is at all ones, with no ripple through the chain. Every state change happens on the rising clock edge, including the clear and the parallel load.

A clear, a parallel load and a count enable are shared by all slices. The clear is an active-high synchronous input. Inside the block it becomes each slice's active-low master clear. The clear wins over a load, and a load wins over counting, whatever the count enable is doing. An optional modulus shortens the sequence. When it is enabled, the block decodes the count value one below the modulus while counting, and feeds that decode into the synchronous clear, so the counter runs from 0 up to modulus−1.

Top module: `cascade_counter`

## Requirements
- R1: With `rst` high at a rising edge, `count` becomes 0 on that edge, whatever `load_n`, `cnt_en`, `data_in` and the modulus inputs are.
- R2: With `rst` low and `load_n` low at a rising edge, `count` takes `data_in` on that edge, whatever `cnt_en` is.
- R3: With `rst` low, `load_n` high and `cnt_en` high at a rising edge, and no modulus clear due, `count` increases by one on that edge.
- R4: With `rst` low, `load_n` high and `cnt_en` low at a rising edge, `count` keeps its value.
- R5: `tc` is high exactly when `cnt_en` is high and every bit of `count` is 1. It follows `cnt_en` combinationally, without waiting for a clock edge.
- R6: With no clear, no load and no modulus clear, the bits above the lowest 4-bit slice change only on an edge at which the lowest slice is at 4'hF. The carry reaches the top slice on the same edge, so 0x0FF goes to 0x100 and 0x7FF goes to 0x800 in one step.
- R7: With `mod_en` high, counting from `mod_val`−1 (computed modulo 2^W) takes `count` to 0. A `mod_val` of 0 therefore gives the full 2^W sequence.
- R8: A load at a count of `mod_val`−1 loads `data_in`: a load overrides the modulus clear.
- R9: With `mod_en` low, counting from all ones wraps `count` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous clear, active high, highest priority |
| load_n | input | 1 | Parallel load, active low |
| cnt_en | input | 1 | Count enable for all slices and carry-in of the lowest slice |
| data_in | input | NUM_SLICES*4 | Value taken by a load |
| mod_en | input | 1 | Enables the shortened modulus sequence |
| mod_val | input | NUM_SLICES*4 | Modulus M. The sequence runs 0 to M−1 |
| count | output | NUM_SLICES*4 | Current count |
| tc | output | 1 | Terminal count: all ones while `cnt_en` is high |

## Verification
A carry through every slice at once, such as 0x7FF to 0x800 or all ones to zero, needs thousands of count cycles if it is only reached from reset. The stimulus therefore loads values just below these boundaries and then counts across them. Random loads are biased toward values whose low slices are all ones. A load landing exactly on `mod_val`−1 is just as rare, so a directed case sets that up. Random segments also use small moduli, so that the modulus clear fires often.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    localparam int SLICE_W = 4;

    typedef struct packed {
        logic mr_n;
        logic pe_n;
        logic cep;
        logic cet;
    } slice_ctl_t;

    typedef enum logic [1:0] {
        ACT_CLEAR,
        ACT_LOAD,
        ACT_COUNT,
        ACT_HOLD
    } slice_act_e;

    function automatic slice_act_e slice_action(slice_ctl_t c);
        if (!c.mr_n)
            return ACT_CLEAR;
        else if (!c.pe_n)
            return ACT_LOAD;
        else if (c.cep && c.cet)
            return ACT_COUNT;
        else
            return ACT_HOLD;
    endfunction

    function automatic logic slice_full(logic [SLICE_W-1:0] v);
        return &v;
    endfunction

endpackage

// File: rtl/cnt_slice.sv
module cnt_slice
    import cnt_pkg::*;
(
    input  logic               clk,
    input  slice_ctl_t         ctl,
    input  logic [SLICE_W-1:0] d,
    output logic [SLICE_W-1:0] q,
    output logic               tc
);

    slice_act_e act;

    always_comb act = slice_action(ctl);

    always_ff @(posedge clk) begin
        unique case (act)
            ACT_CLEAR: q <= '0;
            ACT_LOAD:  q <= d;
            ACT_COUNT: q <= q + 1'b1;
            default:   q <= q;
        endcase
    end

    // carry flag depends on carry-in enable only, not on the parallel enable
    always_comb tc = ctl.cet & slice_full(q);

endmodule

// File: rtl/cnt_mod_decode.sv
module cnt_mod_decode #(
    parameter int W = 12
) (
    input  logic [W-1:0] count,
    input  logic [W-1:0] mod_val,
    input  logic         mod_en,
    input  logic         cnt_en,
    input  logic         load_n,
    output logic         mod_clr
);

    logic [W-1:0] last_val;

    // mod_val of 0 wraps to all ones, which matches the natural rollover
    always_comb last_val = mod_val - W'(1);

    always_comb mod_clr = mod_en && cnt_en && load_n && (count == last_val);

endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
    import cnt_pkg::*;
#(
    parameter int NUM_SLICES = 3,
    localparam int W = NUM_SLICES * SLICE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_n,
    input  logic         cnt_en,
    input  logic [W-1:0] data_in,
    input  logic         mod_en,
    input  logic [W-1:0] mod_val,
    output logic [W-1:0] count,
    output logic         tc
);

    logic                                  mod_clr;
    logic                                  mr_n;
    logic [NUM_SLICES:0]                   carry;
    logic [NUM_SLICES-1:0][SLICE_W-1:0]    q_arr;

    cnt_mod_decode #(.W(W)) u_mod (
        .count   (count),
        .mod_val (mod_val),
        .mod_en  (mod_en),
        .cnt_en  (cnt_en),
        .load_n  (load_n),
        .mod_clr (mod_clr)
    );

    always_comb mr_n = !(rst || mod_clr);
    always_comb carry[0] = cnt_en;

    for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
        slice_ctl_t ctl;
        always_comb begin
            ctl.mr_n = mr_n;
            ctl.pe_n = load_n;
            ctl.cep  = cnt_en;
            ctl.cet  = carry[i];
        end
        cnt_slice u_slice (
            .clk (clk),
            .ctl (ctl),
            .d   (data_in[i*SLICE_W +: SLICE_W]),
            .q   (q_arr[i]),
            .tc  (carry[i+1])
        );
    end

    always_comb count = q_arr;
    always_comb tc    = carry[NUM_SLICES];

endmodule

// File: rtl/cascade_counter_chk.sv
module cascade_counter_chk #(
    parameter int W  = 12,
    parameter int SW = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         load_n,
    input logic         cnt_en,
    input logic [W-1:0] data_in,
    input logic         mod_en,
    input logic [W-1:0] mod_val,
    input logic [W-1:0] count,
    input logic         tc,
    input logic         mod_clr
);

    a_r1_clear: assert property (@(posedge clk)
        rst |=> (count == '0));

    a_r2_load: assert property (@(posedge clk) disable iff (rst)
        (!rst && !load_n) |=> (count == $past(data_in)));

    a_r3_count: assert property (@(posedge clk) disable iff (rst)
        (!rst && load_n && cnt_en && !mod_clr) |=> (count == $past(count) + W'(1)));

    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (!rst && load_n && !cnt_en) |=> $stable(count));

    a_r5_tc: assert property (@(posedge clk) disable iff (rst)
        tc == (cnt_en && (&count)));

    a_r6_upper_on_carry: assert property (@(posedge clk) disable iff (rst)
        (!rst && load_n && !mod_clr && !(&count[SW-1:0])) |=> $stable(count[W-1:SW]));

    a_r7_mod_wrap: assert property (@(posedge clk) disable iff (rst)
        (!rst && load_n && cnt_en && mod_en && (count == mod_val - W'(1))) |=> (count == '0));

    a_r8_load_over_mod: assert property (@(posedge clk) disable iff (rst)
        (!rst && !load_n) |-> !mod_clr);

endmodule

bind cascade_counter cascade_counter_chk #(.W(W), .SW(cnt_pkg::SLICE_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .load_n  (load_n),
    .cnt_en  (cnt_en),
    .data_in (data_in),
    .mod_en  (mod_en),
    .mod_val (mod_val),
    .count   (count),
    .tc      (tc),
    .mod_clr (mod_clr)
);

// File: tb/cascade_counter_tb_top.sv
module cascade_counter_tb_top;

    localparam int NS = 3;
    localparam int W  = NS * 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load_n = 1'b1;
    logic         cnt_en = 1'b0;
    logic [W-1:0] data_in = '0;
    logic         mod_en = 1'b0;
    logic [W-1:0] mod_val = '0;
    logic [W-1:0] count;
    logic         tc;

    int checks = 0;
    int fails  = 0;
    logic [W-1:0] exp_cnt = '0;

    always #2.5 clk = ~clk;

    cascade_counter #(.NUM_SLICES(NS)) dut_i (
        .clk(clk), .rst(rst), .load_n(load_n), .cnt_en(cnt_en),
        .data_in(data_in), .mod_en(mod_en), .mod_val(mod_val),
        .count(count), .tc(tc)
    );

    function automatic logic [W-1:0] model_next(
        logic [W-1:0] cur, logic r, logic ld_n, logic en,
        logic me, logic [W-1:0] d, logic [W-1:0] mv);
        if (r) return '0;
        if (!ld_n) return d;
        if (!en) return cur;
        if (me && cur == W'(mv - 1)) return '0;
        return cur + 1'b1;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // called at a falling edge; applies inputs, checks tc, clocks, checks count
    task automatic cyc(input logic r, input logic ld_n, input logic en, input logic me,
                       input logic [W-1:0] d, input logic [W-1:0] mv,
                       input string req, input string tc_req);
        rst = r; load_n = ld_n; cnt_en = en; mod_en = me; data_in = d; mod_val = mv;
        #1;
        check(tc_req, W'(tc), W'(en && (&exp_cnt)));
        @(posedge clk);
        exp_cnt = model_next(exp_cnt, r, ld_n, en, me, d, mv);
        @(negedge clk);
        check(req, count, exp_cnt);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #1000000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual=hung expected=done");
        summary();
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        // R1: clear wins over load and count
        cyc(1, 0, 1, 0, 12'hABC, 0, "R1 clear over load", "R5 tc");
        check("R1 reset state", count, '0);
        // R2: load with count enable low
        cyc(0, 0, 0, 0, 12'h123, 0, "R2 load enable low", "R5 tc");
        cyc(0, 0, 1, 0, 12'h005, 0, "R2 load enable high", "R5 tc");
        // R3: counting
        for (int i = 0; i < 4; i++) cyc(0, 1, 1, 0, 0, 0, "R3 increment", "R5 tc");
        // R4: hold
        for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0, 12'hFFF, 0, "R4 hold", "R5 tc");
        // R6: carries across slices
        cyc(0, 0, 0, 0, 12'h0FF, 0, "R2 load", "R5 tc");
        cyc(0, 1, 1, 0, 0, 0, "R6 carry 0FF->100", "R5 tc");
        cyc(0, 0, 0, 0, 12'h7FF, 0, "R2 load", "R5 tc");
        cyc(0, 1, 1, 0, 0, 0, "R6 carry 7FF->800", "R5 tc");
        cyc(0, 0, 0, 0, 12'h0EF, 0, "R2 load", "R5 tc");
        cyc(0, 1, 1, 0, 0, 0, "R6 no carry 0EF->0F0", "R5 tc");
        // R5 and R9: terminal count and wrap
        cyc(0, 0, 0, 0, 12'hFFF, 0, "R2 load", "R5 tc");
        cyc(0, 1, 0, 0, 0, 0, "R4 hold at max", "R5 tc low when disabled");
        cyc(0, 1, 1, 0, 0, 0, "R9 wrap to zero", "R5 tc high at max");
        // R7: modulus 10
        for (int i = 0; i < 12; i++) cyc(0, 1, 1, 1, 0, 12'd10, "R7 modulus 10", "R5 tc");
        // R7: modulus 0 acts as full range
        cyc(0, 0, 0, 1, 12'hFFE, 0, "R2 load", "R5 tc");
        cyc(0, 1, 1, 1, 0, 0, "R7 mod0 FFE->FFF", "R5 tc");
        cyc(0, 1, 1, 1, 0, 0, "R7 mod0 wrap", "R5 tc");
        // R8: load at M-1 with counting enabled
        cyc(0, 0, 0, 1, 12'd6, 12'd7, "R2 load", "R5 tc");
        cyc(0, 0, 1, 1, 12'h3A5, 12'd7, "R8 load over modulus", "R5 tc");
        // random segments
        for (int seg = 0; seg < 40; seg++) begin
            logic me;
            logic [W-1:0] mv;
            me = ($urandom % 2) == 1;
            mv = (($urandom % 3) == 0) ? W'($urandom) : W'($urandom % 40);
            for (int i = 0; i < 80; i++) begin
                logic r, ld_n, en;
                logic [W-1:0] d;
                r    = ($urandom % 50) == 0;
                ld_n = ($urandom % 10) != 0;
                en   = ($urandom % 10) < 7;
                d    = W'($urandom);
                if (($urandom % 3) == 0) d[3:0] = 4'hF;
                if (($urandom % 4) == 0) d[7:4] = 4'hF;
                cyc(r, ld_n, en, me, d, mv, "R3 random sequence", "R5 random tc");
            end
        end
        summary();
    end

endmodule